// File: doc/BRIEF.md
# Programmable Line Clamp Pulse Generator

This block drives two active-low per-line timing strobes for an image-sensor readout front end. One marks the dark-pixel clamp window and the other is a pre-blank strobe. A line-sync pulse starts each line. From that point a pixel counter measures position in pixel clocks. For each strobe, a start level and two toggle positions set where the output inverts along the line.

The block holds ten independent pattern sets, one for each vertical sequence. At line sync, a sequence-select input picks the set that governs the next line, so the clamp and blank patterns can differ between readout regions. The chosen set is copied into a per-line snapshot. After that copy, neither register writes nor changes on the select input can disturb a line that is already running. A simple write port loads the pattern sets. The address holds a sequence index, a strobe select and a field select.

Top module: `line_clamp_gen`

## Requirements
- R1: After synchronous reset, every set holds start level 1 with both toggle positions at 0, and `clamp_n` and `blank_n` are high.
- R2: A 12-bit pixel position is 0 in the first cycle after the clock edge that samples `line_sync` high. It then rises by one per clock and saturates at 4095.
- R3: During pixel p of a line, `clamp_n` equals start_level XOR (p >= toggle1) XOR (p >= toggle2), using the snapshotted clamp fields.
- R4: `blank_n` follows the same rule from its own snapshotted fields and is independent of the clamp fields.
- R5: The two toggles act independently. Equal toggle positions give no net change, and a second toggle below the first inverts first.
- R6: The set index is taken from `seq_sel` only at line sync. Changing `seq_sel` in the middle of a line has no effect on the outputs.
- R7: A write to the active set in the middle of a line takes effect only from the next line sync. A write in the same cycle as line sync takes effect one line later.
- R8: A toggle position that the line never reaches never fires, and the output holds its level until the next line sync. A toggle at 4095 fires and stays applied while the position is saturated.
- R9: Write address = {seq[3:0], strobe, field[1:0]}. Strobe 0 selects the clamp and 1 selects the blank. Field 0 is the start level (`wr_data[0]`), 1 is toggle1 and 2 is toggle2. Field 3 and sequence indices 10 to 15 are ignored.
- R10: A `seq_sel` of 10 or more at line sync keeps the set already in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_sync | input | 1 | One-cycle line start pulse |
| seq_sel | input | 4 | Vertical sequence index for the next line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | {sequence, strobe, field} write address |
| wr_data | input | 12 | Write data (start level in bit 0) |
| clamp_n | output | 1 | Active-low dark-pixel clamp strobe |
| blank_n | output | 1 | Active-low pre-blank strobe |

## Verification
A register write and a line sync can land on the same clock edge. When they do, the snapshot copy and the bank update compete for the same set. The bench provokes this by raising `wr_en` and `line_sync` together on the active set. It then checks that the line which follows still shows the old pattern and that the line after it shows the new one. A second collision pairs a mid-line change of `seq_sel` with a running line, and that line must keep its pattern pixel by pixel.

// File: rtl/lpg_pkg.sv
// Shared widths, field codes and configuration types for the line clamp
// pulse generator. Assumes two strobes per set and 12-bit pixel positions.
package lpg_pkg;
    localparam int POS_W       = 12;
    localparam int NUM_PULSE   = 2;
    localparam int PULSE_CLAMP = 0;
    localparam int PULSE_BLANK = 1;
    localparam int FLD_W       = 2;
    localparam int PSEL_W      = 1;

    typedef enum logic [FLD_W-1:0] {
        FLD_LEVEL = 2'd0,
        FLD_TOG1  = 2'd1,
        FLD_TOG2  = 2'd2,
        FLD_RSVD  = 2'd3
    } field_e;

    typedef struct packed {
        logic             level;
        logic [POS_W-1:0] tog1;
        logic [POS_W-1:0] tog2;
    } pulse_cfg_t;

    typedef pulse_cfg_t [NUM_PULSE-1:0] pulse_set_t;

    localparam pulse_cfg_t PULSE_RESET = '{level: 1'b1, tog1: '0, tog2: '0};
endpackage

// File: rtl/lpg_cfg_bank.sv
// Bank of per-sequence strobe configurations. Decodes the write address into
// sequence, strobe and field, and provides a combinational read of one set.
// Assumes the caller ignores the read data when the index is out of range.
module lpg_cfg_bank
    import lpg_pkg::*;
#(
    parameter int NUM_SEQ = 10,
    parameter int SEQ_W   = $clog2(NUM_SEQ + 1),
    parameter int ADDR_W  = SEQ_W + PSEL_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [POS_W-1:0]  wr_data,
    input  logic [SEQ_W-1:0]  rd_idx,
    output pulse_set_t        rd_set
);
    logic [SEQ_W-1:0]  wr_seq;
    logic [PSEL_W-1:0] wr_psel;
    field_e            wr_fld;
    pulse_cfg_t        cfg_arr [NUM_SEQ][NUM_PULSE];

    // Split the write address into its three fields.
    always_comb begin
        wr_seq  = wr_addr[ADDR_W-1 -: SEQ_W];
        wr_psel = wr_addr[FLD_W +: PSEL_W];
        wr_fld  = field_e'(wr_addr[FLD_W-1:0]);
    end

    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
        for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
            pulse_cfg_t cfg_q;
            logic       hit;

            assign hit = wr_en && (wr_seq == SEQ_W'(s)) && (wr_psel == PSEL_W'(p));

            // Hold one strobe configuration and update the addressed field.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= PULSE_RESET;
                end else if (hit) begin
                    case (wr_fld)
                        FLD_LEVEL: cfg_q.level <= wr_data[0];
                        FLD_TOG1:  cfg_q.tog1  <= wr_data;
                        FLD_TOG2:  cfg_q.tog2  <= wr_data;
                        default:   cfg_q       <= cfg_q;
                    endcase
                end
            end

            assign cfg_arr[s][p] = cfg_q;
        end
    end

    // Select the set addressed by the read index.
    always_comb begin
        for (int p = 0; p < NUM_PULSE; p++) rd_set[p] = cfg_arr[0][p];
        for (int s = 1; s < NUM_SEQ; s++) begin
            if (rd_idx == SEQ_W'(s)) begin
                for (int p = 0; p < NUM_PULSE; p++) rd_set[p] = cfg_arr[s][p];
            end
        end
    end
endmodule

// File: rtl/lpg_set_latch.sv
// Per-line snapshot of the selected configuration set. Captures at line sync
// when the index is in range, otherwise keeps the previous snapshot.
module lpg_set_latch
    import lpg_pkg::*;
#(
    parameter int NUM_SEQ = 10,
    parameter int SEQ_W   = $clog2(NUM_SEQ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_sync,
    input  logic [SEQ_W-1:0] sel,
    input  pulse_set_t       bank_set,
    output pulse_set_t       snap
);
    logic sel_ok;

    // Flag whether the requested sequence index exists.
    always_comb sel_ok = (sel < SEQ_W'(NUM_SEQ));

    // Load the snapshot at line start, hold it for the rest of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PULSE; p++) snap[p] <= PULSE_RESET;
        end else if (line_sync && sel_ok) begin
            snap <= bank_set;
        end
    end
endmodule

// File: rtl/lpg_pixel_counter.sv
// Pixel position within the line. Cleared by line sync, saturates at its
// maximum so that toggles beyond the line never retrigger by wrap-around.
module lpg_pixel_counter
    import lpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_sync,
    output logic [POS_W-1:0] pix_cnt
);
    localparam logic [POS_W-1:0] CNT_MAX = '1;

    // Count pixels from the line start, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pix_cnt <= '0;
        else if (line_sync)         pix_cnt <= '0;
        else if (pix_cnt != CNT_MAX) pix_cnt <= pix_cnt + 1'b1;
    end
endmodule

// File: rtl/lpg_pulse_shaper.sv
// Derives one strobe level from the pixel position and a configuration.
// Each toggle position inverts the start level once it has been reached.
module lpg_pulse_shaper
    import lpg_pkg::*;
(
    input  pulse_cfg_t       cfg,
    input  logic [POS_W-1:0] pix_cnt,
    output logic             level
);
    logic past1, past2;

    // Compare the position against both toggles and fold the results in.
    always_comb begin
        past1 = (pix_cnt >= cfg.tog1);
        past2 = (pix_cnt >= cfg.tog2);
        level = cfg.level ^ past1 ^ past2;
    end
endmodule

// File: rtl/line_clamp_gen.sv
// Top level: register bank, per-line snapshot, pixel counter and one shaper
// per strobe. Assumes line_sync is a single-cycle pulse in the clk domain.
module line_clamp_gen
    import lpg_pkg::*;
#(
    parameter int NUM_SEQ = 10,
    parameter int SEQ_W   = $clog2(NUM_SEQ + 1),
    parameter int ADDR_W  = SEQ_W + PSEL_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_sync,
    input  logic [SEQ_W-1:0]  seq_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [POS_W-1:0]  wr_data,
    output logic              clamp_n,
    output logic              blank_n
);
    pulse_set_t             bank_set;
    pulse_set_t             snap_set;
    logic [POS_W-1:0]       pix_cnt;
    logic [NUM_PULSE-1:0]   levels;

    lpg_cfg_bank #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_idx(seq_sel), .rd_set(bank_set)
    );

    lpg_set_latch #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .sel(seq_sel),
        .bank_set(bank_set), .snap(snap_set)
    );

    lpg_pixel_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .pix_cnt(pix_cnt)
    );

    for (genvar p = 0; p < NUM_PULSE; p++) begin : g_shape
        lpg_pulse_shaper u_shape (
            .cfg(snap_set[p]), .pix_cnt(pix_cnt), .level(levels[p])
        );
    end

    assign clamp_n = levels[PULSE_CLAMP];
    assign blank_n = levels[PULSE_BLANK];
endmodule

// File: rtl/lpg_line_pulse_chk.sv
// Property checker for line_clamp_gen, attached by bind below.
module lpg_line_pulse_chk
    import lpg_pkg::*;
#(
    parameter int NUM_SEQ = 10,
    parameter int SEQ_W   = $clog2(NUM_SEQ + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_sync,
    input logic [SEQ_W-1:0] seq_sel,
    input logic [POS_W-1:0] pix_cnt,
    input pulse_set_t       snap,
    input logic             clamp_n,
    input logic             blank_n
);
    localparam logic [POS_W-1:0] CNT_MAX = '1;

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (clamp_n && blank_n));

    assert_count_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_sync |=> (pix_cnt == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_sync && pix_cnt != CNT_MAX) |=> (pix_cnt == $past(pix_cnt) + 1'b1));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_sync && pix_cnt == CNT_MAX) |=> (pix_cnt == CNT_MAX));

    assert_set_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_sync |=> $stable(snap));

    assert_bad_sel_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sync && seq_sel >= SEQ_W'(NUM_SEQ)) |=> $stable(snap));

    assert_clamp_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(line_sync) && clamp_n != $past(clamp_n))
        |-> (pix_cnt == snap[PULSE_CLAMP].tog1 || pix_cnt == snap[PULSE_CLAMP].tog2));

    assert_blank_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(line_sync) && blank_n != $past(blank_n))
        |-> (pix_cnt == snap[PULSE_BLANK].tog1 || pix_cnt == snap[PULSE_BLANK].tog2));
endmodule

bind line_clamp_gen lpg_line_pulse_chk #(.NUM_SEQ(NUM_SEQ), .SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .seq_sel(seq_sel),
    .pix_cnt(pix_cnt), .snap(snap_set), .clamp_n(clamp_n), .blank_n(blank_n)
);

// File: tb/line_clamp_gen_test.sv
// Directed bench for line_clamp_gen with a model of the pattern sets.
module line_clamp_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSEQ       = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_sync = 1'b0;
    logic [3:0]  seq_sel = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        clamp_n, blank_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int m_lvl [NSEQ][2];
    int m_t1  [NSEQ][2];
    int m_t2  [NSEQ][2];
    int a_lvl [2];
    int a_t1  [2];
    int a_t2  [2];
    int cur_p = 0;

    line_clamp_gen uut (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .seq_sel(seq_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clamp_n(clamp_n), .blank_n(blank_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == WD_LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d (pixel %0d)", tag, act, exp, cur_p);
        end
    endtask

    task automatic advance();
        @(negedge clk);
        if (cur_p < 4095) cur_p++;
    endtask

    function automatic int exp_level(input int s);
        return a_lvl[s] ^ int'(cur_p >= a_t1[s]) ^ int'(cur_p >= a_t2[s]);
    endfunction

    // Compare both strobes with the model, then move one pixel on.
    task automatic check_pixels(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk({tag, " clamp"}, int'(clamp_n), exp_level(0));
            chk({tag, " blank"}, int'(blank_n), exp_level(1));
            advance();
        end
    endtask

    function automatic void mirror_write(input int s, input int p, input int f, input int d);
        if (s < NSEQ) begin
            if (f == 0) m_lvl[s][p] = d & 1;
            else if (f == 1) m_t1[s][p] = d;
            else if (f == 2) m_t2[s][p] = d;
        end
    endfunction

    function automatic void take_snapshot(input int s);
        if (s < NSEQ) begin
            for (int p = 0; p < 2; p++) begin
                a_lvl[p] = m_lvl[s][p]; a_t1[p] = m_t1[s][p]; a_t2[p] = m_t2[s][p];
            end
        end
    endfunction

    task automatic write_reg(input int s, input int p, input int f, input int d);
        wr_en = 1'b1; wr_addr = {4'(s), 1'(p), 2'(f)}; wr_data = 12'(d);
        advance();
        wr_en = 1'b0;
        mirror_write(s, p, f, d);
    endtask

    task automatic set_pattern(input int s, input int p, input int lvl, input int t1, input int t2);
        write_reg(s, p, 0, lvl);
        write_reg(s, p, 1, t1);
        write_reg(s, p, 2, t2);
    endtask

    task automatic start_line(input int s);
        line_sync = 1'b1; seq_sel = 4'(s);
        @(negedge clk);
        line_sync = 1'b0;
        take_snapshot(s);
        cur_p = 0;
    endtask

    task automatic test_reset();
        chk("R1 clamp after reset", int'(clamp_n), 1);
        chk("R1 blank after reset", int'(blank_n), 1);
        start_line(3);
        check_pixels(20, "R1 default set");
    endtask

    task automatic test_basic();
        set_pattern(0, 0, 1, 5, 12);
        set_pattern(0, 1, 1, 20, 30);
        start_line(0);
        check_pixels(40, "R3 R4 R2 basic line");
    endtask

    task automatic test_orderings();
        set_pattern(1, 0, 0, 8, 8);
        set_pattern(1, 1, 1, 15, 4);
        start_line(1);
        check_pixels(30, "R5 equal and reversed toggles");
    endtask

    task automatic test_select_midline();
        start_line(0);
        check_pixels(8, "R6 before sel change");
        seq_sel = 4'd1;
        check_pixels(32, "R6 sel changed mid-line");
        start_line(1);
        check_pixels(20, "R6 new set at sync");
    endtask

    task automatic test_write_active();
        start_line(0);
        check_pixels(3, "R7 pre-write");
        write_reg(0, 0, 1, 25);
        check_pixels(30, "R7 mid-line write ignored");
        start_line(0);
        check_pixels(35, "R7 write applied next line");
        // Write to the active set in the same cycle as line sync.
        wr_en = 1'b1; wr_addr = {4'd0, 1'b1, 2'd1}; wr_data = 12'd2;
        start_line(0);
        wr_en = 1'b0;
        mirror_write(0, 1, 1, 2);
        check_pixels(35, "R7 coincident write old line");
        start_line(0);
        check_pixels(35, "R7 coincident write next line");
    endtask

    task automatic test_beyond_line();
        set_pattern(2, 0, 1, 3000, 4095);
        set_pattern(2, 1, 1, 100, 200);
        start_line(2);
        check_pixels(50, "R8 short line no toggle");
        start_line(2);
        check_pixels(4200, "R8 R2 saturation");
    endtask

    task automatic test_address_map();
        set_pattern(3, 0, 1, 5, 9);
        write_reg(3, 0, 3, 2);
        write_reg(12, 0, 1, 7);
        write_reg(12, 1, 0, 0);
        for (int s = 2; s <= 4; s++) begin
            start_line(s);
            check_pixels(20, "R9 ignored writes");
        end
        start_line(3);
        check_pixels(15, "R9 field map seq3");
    endtask

    task automatic test_bad_select();
        start_line(1);
        check_pixels(20, "R10 baseline");
        start_line(12);
        check_pixels(30, "R10 out-of-range select keeps set");
        start_line(15);
        check_pixels(20, "R10 select 15 keeps set");
    endtask

    initial begin
        for (int s = 0; s < NSEQ; s++) begin
            for (int p = 0; p < 2; p++) begin
                m_lvl[s][p] = 1; m_t1[s][p] = 0; m_t2[s][p] = 0;
            end
        end
        take_snapshot(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_orderings();
        test_select_midline();
        test_write_active();
        test_beyond_line();
        test_address_map();
        test_bad_select();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule